// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block provides the configuration interface of a peripheral controller. A host reaches it through two adjacent addresses on a byte-wide I/O bus. The lower address is the index port and the next address is the data port. At reset the configuration registers are locked. They open only after the host writes a fixed four-byte key to the index port. The final byte of the key depends on which of the two supported base addresses the instance answers at.

While the block is open, the host writes a register number to the index port. It then reads or writes the selected register through the data port. The register set has the following contents:

- a read-only two-byte chip identity;
- a logical-device select register;
- a global flash-decode control byte, which drives decode-window enables, a host flash-write enable and a chip-select pin choice;
- a pair of registers holding the SPI engine's base address, banked behind logical device 7.

A dedicated write closes the block again.

Top module: `cfgu_gate`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0), `spi_base`=0x0000, `win_en`=0, `flash_wr_en`=0, `cs_alt`=0 and `io_rdata`=0x00.
- R2: Four index-port writes of 0x87, 0x01, 0x55 and K4 open the block at the clock edge that takes the fourth byte. K4 is 0x55 when `BASE_ADDR` is 0x2E and 0xAA when it is 0x4E. Any other fourth byte leaves the block locked.
- R3: A mismatching key byte restarts matching. A mismatching byte equal to 0x87 counts as the first key byte, so matching continues at step two.
- R4: While locked, data-port reads return 0xFF. Data-port writes and non-key index writes while locked change no register.
- R5: While open, index 0x20 reads 0x87 and index 0x21 reads 0x16, and writes to them are ignored. An index-port read returns the current index, or 0xFF while locked.
- R6: Writing 0x02 to index 0x02 through the data port locks the block at that edge. Any other value written there leaves the block open.
- R7: Index 0x07 is the read/write logical-device number. When it equals 7, indices 0x64 and 0x65 read and write the high and low bytes of `spi_base`. For any other device number these indices read 0x00 and writes to them are ignored.
- R8: Index 0x24 is a read/write byte. Bits 3:1 drive `win_en`, bit 4 drives `flash_wr_en` and bit 5 drives `cs_alt`.
- R9: A read strobe at either of the block's two addresses gives `io_rvalid`=1 and the read data on the following cycle. A read at any other address gives `io_rvalid`=0.
- R10: While open, any index not named above reads 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe, one cycle per byte |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read hit |
| cfg_open | output | 1 | Configuration registers unlocked |
| spi_base | output | 16 | SPI engine base address |
| win_en | output | 3 | Flash decode window enables |
| flash_wr_en | output | 1 | Host writes to flash enabled |
| cs_alt | output | 1 | Alternate flash chip-select pin selected |

## Verification
Every register write, including the fourth key byte and the lock write, takes effect at the clock edge that samples the strobe. The new `cfg_open`, `spi_base` and decode outputs are therefore due one cycle after the strobe. Read data and `io_rvalid` are registered, so they are also due on the cycle after the read strobe. The bench drives each strobe for a single cycle starting at a falling edge. It samples at the next falling edge, which is half a cycle after the edge that produces the result. Two instances at the two base addresses share one bus, so the same stimulus also checks that each instance ignores the other's addresses.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
  localparam logic [7:0] KEY_B0    = 8'h87;
  localparam logic [7:0] KEY_B1    = 8'h01;
  localparam logic [7:0] KEY_B2    = 8'h55;
  localparam logic [7:0] KEY_B3_LO = 8'h55;
  localparam logic [7:0] KEY_B3_HI = 8'hAA;

  localparam logic [7:0] IX_EXIT   = 8'h02;
  localparam logic [7:0] EXIT_VAL  = 8'h02;
  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_ID_HI  = 8'h20;
  localparam logic [7:0] IX_ID_LO  = 8'h21;
  localparam logic [7:0] IX_GLOB   = 8'h24;
  localparam logic [7:0] IX_BASE_H = 8'h64;
  localparam logic [7:0] IX_BASE_L = 8'h65;

  localparam logic [7:0] ID_HI     = 8'h87;
  localparam logic [7:0] ID_LO     = 8'h16;
  localparam logic [7:0] LOCKED_RD = 8'hFF;

  function automatic logic [7:0] key_at(input logic [1:0] step, input logic alt);
    case (step)
      2'd0:    key_at = KEY_B0;
      2'd1:    key_at = KEY_B1;
      2'd2:    key_at = KEY_B2;
      default: key_at = alt ? KEY_B3_HI : KEY_B3_LO;
    endcase
  endfunction
endpackage

// File: rtl/cfgu_key_seq.sv
module cfgu_key_seq #(
  parameter logic ALT_KEY = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       lock_req,
  output logic       open_o
);
  import cfgu_pkg::*;

  localparam int         STEPS     = 4;
  localparam logic [1:0] LAST_STEP = 2'(STEPS - 1);

  logic [1:0] step_q;
  logic [7:0] want;

  assign want = key_at(step_q, ALT_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 2'd0;
      open_o <= 1'b0;
    end else if (lock_req) begin
      open_o <= 1'b0;
      step_q <= 2'd0;
    end else if (key_wr) begin
      if (key_byte == want) begin
        if (step_q == LAST_STEP) begin
          open_o <= 1'b1;
          step_q <= 2'd0;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end else begin
        step_q <= (key_byte == KEY_B0) ? 2'd1 : 2'd0;
      end
    end
  end
endmodule

// File: rtl/cfgu_regs.sv
module cfgu_regs #(
  parameter logic [7:0] SPI_LDN = 8'd7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        open_i,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic        idx_rd,
  input  logic        dat_rd,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic [7:0]  cur_idx,
  output logic        lock_req,
  output logic [15:0] spi_base,
  output logic [7:0]  glob
);
  import cfgu_pkg::*;

  localparam int BANK_BYTES = 2;

  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic [7:0] base_q [BANK_BYTES];
  logic       bank_sel;
  logic       wr_ok;
  logic [7:0] mux_val;

  assign bank_sel = (ldn_q == SPI_LDN);
  assign wr_ok    = dat_wr && open_i;
  assign lock_req = wr_ok && (idx_q == IX_EXIT) && (wdata == EXIT_VAL);
  assign cur_idx  = idx_q;
  assign spi_base = {base_q[0], base_q[1]};

  always_comb begin
    case (idx_q)
      IX_ID_HI:  mux_val = ID_HI;
      IX_ID_LO:  mux_val = ID_LO;
      IX_LDN:    mux_val = ldn_q;
      IX_GLOB:   mux_val = glob;
      IX_BASE_H: mux_val = bank_sel ? base_q[0] : 8'h00;
      IX_BASE_L: mux_val = bank_sel ? base_q[1] : 8'h00;
      default:   mux_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
      glob  <= 8'h00;
    end else begin
      if (idx_wr && open_i) idx_q <= wdata;
      if (wr_ok && idx_q == IX_LDN)  ldn_q <= wdata;
      if (wr_ok && idx_q == IX_GLOB) glob  <= wdata;
    end
  end

  for (genvar b = 0; b < BANK_BYTES; b++) begin : g_bank
    localparam logic [7:0] MY_IDX = IX_BASE_H + 8'(b);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[b] <= 8'h00;
      end else if (wr_ok && bank_sel && idx_q == MY_IDX) begin
        base_q[b] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      rvalid <= idx_rd || dat_rd;
      if (idx_rd)      rdata <= open_i ? idx_q : LOCKED_RD;
      else if (dat_rd) rdata <= open_i ? mux_val : LOCKED_RD;
    end
  end
endmodule

// File: rtl/cfgu_gate.sv
module cfgu_gate #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter logic [7:0]      SPI_LDN   = 8'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              cfg_open,
  output logic [15:0]       spi_base,
  output logic [2:0]        win_en,
  output logic              flash_wr_en,
  output logic              cs_alt
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;
  localparam logic              ALT_KEY   = (BASE_ADDR == ADDR_W'('h4E));

  logic       hit_idx, hit_dat;
  logic       lock_req;
  logic [7:0] cur_idx;
  logic [7:0] glob;

  assign hit_idx = (io_addr == BASE_ADDR);
  assign hit_dat = (io_addr == DATA_ADDR);

  cfgu_key_seq #(.ALT_KEY(ALT_KEY)) key_i (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (io_wr && hit_idx && !cfg_open),
    .key_byte (io_wdata),
    .lock_req (lock_req),
    .open_o   (cfg_open)
  );

  cfgu_regs #(.SPI_LDN(SPI_LDN)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .open_i   (cfg_open),
    .idx_wr   (io_wr && hit_idx),
    .dat_wr   (io_wr && hit_dat),
    .idx_rd   (io_rd && hit_idx),
    .dat_rd   (io_rd && hit_dat),
    .wdata    (io_wdata),
    .rdata    (io_rdata),
    .rvalid   (io_rvalid),
    .cur_idx  (cur_idx),
    .lock_req (lock_req),
    .spi_base (spi_base),
    .glob     (glob)
  );

  assign win_en      = glob[3:1];
  assign flash_wr_en = glob[4];
  assign cs_alt      = glob[5];
endmodule

// File: rtl/cfgu_gate_chk.sv
module cfgu_gate_chk #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              cfg_open,
  input logic [15:0]       spi_base,
  input logic [7:0]        cur_idx
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;
  localparam logic [7:0] K4 = (BASE_ADDR == ADDR_W'('h4E)) ? 8'hAA : 8'h55;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    io_rd && (io_addr == BASE_ADDR || io_addr == DATA_ADDR) |=> io_rvalid); // R9

  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
    io_rd && io_addr == DATA_ADDR && !cfg_open |=> io_rdata == 8'hFF); // R4

  AST_BASE_HELD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(spi_base)); // R4

  AST_OPEN_BY_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == K4)); // R2

  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_open && io_wr && io_addr == DATA_ADDR && cur_idx == 8'h02 && io_wdata == 8'h02
    |=> !cfg_open); // R6

  AST_ID_HI_READ: assert property (@(posedge clk) disable iff (rst)
    cfg_open && io_rd && io_addr == DATA_ADDR && cur_idx == 8'h20 |=> io_rdata == 8'h87); // R5
endmodule

bind cfgu_gate cfgu_gate_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .io_rvalid (io_rvalid),
  .cfg_open  (cfg_open),
  .spi_base  (spi_base),
  .cur_idx   (cur_idx)
);

// File: tb/cfgu_gate_tb_top.sv
module cfgu_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;

  logic [7:0]  rd_a, rd_b;
  logic        rv_a, rv_b, op_a, op_b;
  logic [15:0] sb_a, sb_b;
  logic [2:0]  we_a, we_b;
  logic        fw_a, fw_b, cs_a, cs_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  m_ldn, m_glb;
  logic [15:0] m_base;

  always #2 clk = ~clk;

  cfgu_gate #(.BASE_ADDR(16'h002E)) dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rd_a), .io_rvalid(rv_a), .cfg_open(op_a),
    .spi_base(sb_a), .win_en(we_a), .flash_wr_en(fw_a), .cs_alt(cs_a));

  cfgu_gate #(.BASE_ADDR(16'h004E)) dut_b (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rd_b), .io_rvalid(rv_b), .cfg_open(op_b),
    .spi_base(sb_b), .win_en(we_b), .flash_wr_en(fw_b), .cs_alt(cs_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] k4);
    wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, k4);
  endtask

  task automatic cfg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(16'h2E, ix); wr(16'h2F, d);
  endtask

  function automatic logic [7:0] model(input logic [7:0] ix);
    case (ix)
      8'h20: model = 8'h87;
      8'h21: model = 8'h16;
      8'h07: model = m_ldn;
      8'h24: model = m_glb;
      8'h64: model = (m_ldn == 8'd7) ? m_base[15:8] : 8'h00;
      8'h65: model = (m_ldn == 8'd7) ? m_base[7:0] : 8'h00;
      default: model = 8'h00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(op_a == 0 && op_b == 0, "R1 open", {op_a, op_b}, 0);
    chk(sb_a == 0, "R1 spi_base", sb_a, 0);
    chk(we_a == 0 && fw_a == 0 && cs_a == 0, "R1 decode", {we_a, fw_a, cs_a}, 0);
    chk(rd_a == 0, "R1 rdata", rd_a, 0);

    // R4 locked read, R9 latency and address decode
    rd(16'h2F);
    chk(rd_a == 8'hFF, "R4 locked read", rd_a, 8'hFF);
    chk(rv_a == 1, "R9 rvalid hit", rv_a, 1);
    chk(rv_b == 0, "R9 rvalid miss", rv_b, 0);
    wr(16'h2F, 8'h12);
    chk(sb_a == 0 && !op_a, "R4 locked write", sb_a, 0);

    // R3 wrong byte restarts
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h00);
    wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    chk(!op_a, "R3 wrong byte", op_a, 0);
    wr(16'h2E, 8'h87); key(16'h2E, 8'h55);
    chk(op_a, "R3 0x87 restart", op_a, 1);

    // R6 exit
    cfg_wr(8'h02, 8'h01);
    chk(op_a, "R6 other value", op_a, 1);
    cfg_wr(8'h02, 8'h02);
    chk(!op_a, "R6 exit", op_a, 0);

    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h87);
    key(16'h2E, 8'h55);
    chk(op_a, "R3 restart mid", op_a, 1);
    cfg_wr(8'h02, 8'h02);

    // R2 sweep of fourth key byte, both bases
    for (int v = 0; v < 256; v++) begin
      key(16'h2E, 8'(v));
      chk(op_a == (v == 8'h55), "R2 key4 base 0x2E", op_a, (v == 8'h55));
      chk(!op_b, "R2 other base closed", op_b, 0);
      if (op_a) cfg_wr(8'h02, 8'h02);
    end
    for (int v = 0; v < 256; v++) begin
      key(16'h4E, 8'(v));
      chk(op_b == (v == 8'hAA), "R2 key4 base 0x4E", op_b, (v == 8'hAA));
      if (op_b) begin wr(16'h4E, 8'h02); wr(16'h4F, 8'h02); end
    end

    // R7 R8 configuration
    key(16'h2E, 8'h55);
    m_ldn = 8'd7; m_glb = 8'h3E; m_base = 16'h1234;
    cfg_wr(8'h07, 8'h07); cfg_wr(8'h64, 8'h12); cfg_wr(8'h65, 8'h34);
    cfg_wr(8'h24, 8'h3E);
    chk(sb_a == 16'h1234, "R7 spi_base", sb_a, 16'h1234);
    chk(we_a == 3'b111 && fw_a && cs_a, "R8 decode 0x3E", {we_a, fw_a, cs_a}, 5'b11111);

    // R5 R7 R8 R10 index sweep
    for (int ix = 0; ix < 256; ix++) begin
      wr(16'h2E, 8'(ix));
      rd(16'h2F);
      chk(rd_a == model(8'(ix)), "R5/R7/R8/R10 index read", rd_a, model(8'(ix)));
    end
    wr(16'h2E, 8'h5A); rd(16'h2E);
    chk(rd_a == 8'h5A, "R5 index readback", rd_a, 8'h5A);

    cfg_wr(8'h30, 8'h55); rd(16'h2F);
    chk(rd_a == 8'h00, "R10 unlisted write", rd_a, 0);
    cfg_wr(8'h20, 8'h00); rd(16'h2F);
    chk(rd_a == 8'h87, "R5 id write ignored", rd_a, 8'h87);

    // R7 banking
    cfg_wr(8'h07, 8'h03); m_ldn = 8'h03;
    wr(16'h2E, 8'h64); rd(16'h2F);
    chk(rd_a == 8'h00, "R7 other bank read", rd_a, 0);
    wr(16'h2F, 8'hAB);
    chk(sb_a == 16'h1234, "R7 other bank write", sb_a, 16'h1234);
    cfg_wr(8'h07, 8'h07);
    wr(16'h2E, 8'h64); rd(16'h2F);
    chk(rd_a == 8'h12, "R7 bank restored", rd_a, 8'h12);

    // R8 second pattern
    cfg_wr(8'h24, 8'h0A);
    chk(we_a == 3'b101 && !fw_a && !cs_a, "R8 decode 0x0A", {we_a, fw_a, cs_a}, 5'b10100);

    // R4 writes while locked
    cfg_wr(8'h02, 8'h02);
    wr(16'h2E, 8'h65); wr(16'h2F, 8'h77);
    chk(sb_a == 16'h1234, "R4 locked base", sb_a, 16'h1234);
    rd(16'h2E);
    chk(rd_a == 8'hFF, "R5 locked index read", rd_a, 8'hFF);
    key(16'h2E, 8'h55);
    wr(16'h2E, 8'h65); rd(16'h2F);
    chk(rd_a == 8'h34, "R4 locked write ignored", rd_a, 8'h34);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule